// File: doc/BRIEF.md
# Cycle-by-Cycle Current Limit Controller

This block drives the two gate enables of one half-bridge from a PWM command and cuts each PWM high phase short when the low-side current sense reports overcurrent. The overcurrent flag arrives from an analog comparator, unsynchronized. It is resynchronized and then evaluated only while the PWM command is high and a leading-edge blanking window has expired. The blanking window masks the switching transient that follows each turn-on.

A trip is held in a latch for the remainder of the PWM period. While the latch is set the high-side device stays off and the low-side device conducts, because synchronous rectification is permanent. The latch clears on the next rising edge of the PWM command, which starts a new period. Every handover between the two devices passes through a dead-time interval with both enables low. This applies whether the handover comes from the PWM command or from a trip.

Top module: `cbc_limit_ctrl`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it is sampled high, `hs_gate_en`, `ls_gate_en` and `limit_active` are all low.
- R2: The overcurrent flag is ignored in the clock cycle in which a PWM rising edge is seen, and in the `BLANK_CYC` cycles that follow. A flag that is present only inside that window leaves `limit_active` low.
- R3: An overcurrent seen after the blanking window, while the PWM command is high, sets `limit_active`. The high side then stays off until the next PWM rising edge, even after the flag returns low.
- R4: The trip latch clears at the PWM rising edge that begins the next period, and `limit_active` is low in the cycle after that edge.
- R5: Without a trip, `hs_gate_en` is high while the PWM command is high, once the dead time has passed.
- R6: The low side conducts while the PWM command is low, and also while a trip holds the high side off. Once the dead time has passed, `ls_gate_en` is high in both cases.
- R7: Every switch from one device to the other leaves both enables low for exactly `DEAD_CYC` clock cycles.
- R8: `hs_gate_en` and `ls_gate_en` are never high in the same cycle.
- R9: `oc_flag_async` crosses a two-stage synchronizer. A flag driven before clock edge n sets `limit_active` after edge n+2, and not earlier.
- R10: The overcurrent flag has no effect while the PWM command is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_cmd | input | 1 | PWM command; high requests high-side conduction |
| oc_flag_async | input | 1 | Overcurrent comparator flag, asynchronous |
| hs_gate_en | output | 1 | High-side gate enable |
| ls_gate_en | output | 1 | Low-side gate enable |
| limit_active | output | 1 | High while the per-period trip latch is set |

## Verification
The block is driven with plain PWM periods of several duty cycles, and with no overcurrent applied. These runs separate the dead-time and following behaviour from the limit path. An overcurrent pulse that lies entirely inside the blanking window is applied. So is a pulse that arrives later and then clears mid-period. Together they distinguish correct masking from a missing or misplaced window, and a true per-period latch from a device that simply follows the flag. An overcurrent held high while the PWM command is low, and one held high across several whole periods, show that the flag acts only during the high phase and that the latch is rearmed at every rising edge.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  typedef enum logic [1:0] {
    LEG_DEAD = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_e;

endpackage

// File: rtl/cbc_sync.sv
module cbc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign d_sync = shreg[STAGES-1];
endmodule

// File: rtl/cbc_blank.sv
module cbc_blank #(
  parameter int CNT_W     = 8,
  parameter int BLANK_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_cmd,
  output logic pwm_rise,
  output logic blank_active
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BLANK_CYC);

  logic             pwm_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] blank_next(input logic rise,
                                                  input logic [CNT_W-1:0] c);
    if (rise)           return LOAD;
    else if (c != '0)   return c - 1'b1;
    else                return c;
  endfunction

  assign pwm_rise     = pwm_cmd & ~pwm_q;
  assign blank_active = pwm_rise | (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      pwm_q <= pwm_cmd;
      cnt_q <= blank_next(pwm_rise, cnt_q);
    end
  end
endmodule

// File: rtl/cbc_trip.sv
module cbc_trip (
  input  logic clk,
  input  logic rst,
  input  logic pwm_cmd,
  input  logic pwm_rise,
  input  logic blank_active,
  input  logic oc_sync,
  output logic trip_set,
  output logic trip_q
);
  assign trip_set = pwm_cmd & ~blank_active & oc_sync;

  always_ff @(posedge clk) begin
    if (rst)           trip_q <= 1'b0;
    else if (pwm_rise) trip_q <= 1'b0;
    else if (trip_set) trip_q <= 1'b1;
  end
endmodule

// File: rtl/cbc_deadtime.sv
module cbc_deadtime
  import cbc_pkg::*;
#(
  parameter int DEAD_W   = 4,
  parameter int DEAD_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic hs_req,
  output logic hs_en,
  output logic ls_en,
  output leg_e leg
);
  localparam logic [DEAD_W-1:0] LOAD = DEAD_W'(DEAD_CYC - 1);

  leg_e              leg_q, leg_d;
  logic [DEAD_W-1:0] dcnt_q, dcnt_d;

  function automatic leg_e wanted(input logic req);
    return req ? LEG_HIGH : LEG_LOW;
  endfunction

  always_comb begin
    leg_d  = leg_q;
    dcnt_d = dcnt_q;
    unique case (leg_q)
      LEG_HIGH: if (!hs_req) begin leg_d = LEG_DEAD; dcnt_d = LOAD; end
      LEG_LOW:  if (hs_req)  begin leg_d = LEG_DEAD; dcnt_d = LOAD; end
      default: begin
        if (dcnt_q == '0) leg_d = wanted(hs_req);
        else              dcnt_d = dcnt_q - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      leg_q  <= LEG_DEAD;
      dcnt_q <= LOAD;
    end else begin
      leg_q  <= leg_d;
      dcnt_q <= dcnt_d;
    end
  end

  assign hs_en = (leg_q == LEG_HIGH);
  assign ls_en = (leg_q == LEG_LOW);
  assign leg   = leg_q;
endmodule

// File: rtl/cbc_limit_ctrl.sv
module cbc_limit_ctrl
  import cbc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BLANK_W     = 8,
  parameter int BLANK_CYC   = 6,
  parameter int DEAD_W      = 4,
  parameter int DEAD_CYC    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_cmd,
  input  logic oc_flag_async,
  output logic hs_gate_en,
  output logic ls_gate_en,
  output logic limit_active
);
  logic oc_sync;
  logic pwm_rise;
  logic blank_active;
  logic trip_set;
  logic trip_q;
  logic hs_req;
  leg_e leg;

  cbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(oc_flag_async), .d_sync(oc_sync)
  );

  cbc_blank #(.CNT_W(BLANK_W), .BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst(rst), .pwm_cmd(pwm_cmd),
    .pwm_rise(pwm_rise), .blank_active(blank_active)
  );

  cbc_trip u_trip (
    .clk(clk), .rst(rst), .pwm_cmd(pwm_cmd), .pwm_rise(pwm_rise),
    .blank_active(blank_active), .oc_sync(oc_sync),
    .trip_set(trip_set), .trip_q(trip_q)
  );

  // a rising edge starts a fresh period, so a stale trip must not block it
  assign hs_req = pwm_cmd & (pwm_rise | ~trip_q);

  cbc_deadtime #(.DEAD_W(DEAD_W), .DEAD_CYC(DEAD_CYC)) u_dead (
    .clk(clk), .rst(rst), .hs_req(hs_req),
    .hs_en(hs_gate_en), .ls_en(ls_gate_en), .leg(leg)
  );

  assign limit_active = trip_q;
endmodule

// File: rtl/cbc_limit_chk.sv
module cbc_limit_chk #(
  parameter int DEAD_CYC = 3
) (
  input logic clk,
  input logic rst,
  input logic pwm_cmd,
  input logic pwm_rise,
  input logic blank_active,
  input logic hs_gate_en,
  input logic ls_gate_en,
  input logic limit_active
);
  logic [7:0] idle_run;

  always_ff @(posedge clk) begin
    if (rst)                          idle_run <= '0;
    else if (hs_gate_en | ls_gate_en) idle_run <= '0;
    else if (idle_run != 8'hFF)       idle_run <= idle_run + 1'b1;
  end

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate_en && ls_gate_en));

  // R7
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(hs_gate_en) || $rose(ls_gate_en)) |-> (idle_run >= 8'(DEAD_CYC)));

  // R2
  blank_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(limit_active) |-> $past(!blank_active && pwm_cmd));

  // R3
  trip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (limit_active && $past(limit_active)) |-> !hs_gate_en);

  // R4
  period_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pwm_rise) |-> !limit_active);
endmodule

bind cbc_limit_ctrl cbc_limit_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (
  .clk(clk), .rst(rst), .pwm_cmd(pwm_cmd), .pwm_rise(pwm_rise),
  .blank_active(blank_active), .hs_gate_en(hs_gate_en),
  .ls_gate_en(ls_gate_en), .limit_active(limit_active)
);

// File: tb/cbc_limit_ctrl_tb_top.sv
module cbc_limit_ctrl_tb_top;
  localparam int BLANK = 6;
  localparam int DEAD  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm = 1'b0;
  logic oc  = 1'b0;
  logic hs, ls, lim;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cbc_limit_ctrl #(.BLANK_CYC(BLANK), .DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst(rst), .pwm_cmd(pwm), .oc_flag_async(oc),
    .hs_gate_en(hs), .ls_gate_en(ls), .limit_active(lim)
  );

  // behavioural reference: cycle ages and a tiny phase tracker
  int m_age = 1000;
  bit m_prev = 0, m_s1 = 0, m_s2 = 0, m_trip = 0;
  int m_phase = 0;          // 0 both off, 1 high side, 2 low side
  int m_left  = DEAD - 1;

  always @(posedge clk) begin
    bit rise, want_hi, arm;
    if (rst) begin
      m_age = 1000; m_prev = 0; m_s1 = 0; m_s2 = 0; m_trip = 0;
      m_phase = 0; m_left = DEAD - 1;
    end else begin
      rise    = pwm && !m_prev;
      arm     = pwm && !rise && (m_age > BLANK) && m_s2;
      want_hi = pwm && (rise || !m_trip);
      if (m_phase == 1 && !want_hi) begin m_phase = 0; m_left = DEAD - 1; end
      else if (m_phase == 2 && want_hi) begin m_phase = 0; m_left = DEAD - 1; end
      else if (m_phase == 0) begin
        if (m_left == 0) m_phase = want_hi ? 1 : 2;
        else m_left--;
      end
      if (rise) m_trip = 0; else if (arm) m_trip = 1;
      m_age  = rise ? 1 : m_age + 1;
      m_s2 = m_s1; m_s1 = oc; m_prev = pwm;
    end
  end

  task automatic check(string tag, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, plus gap and overlap monitors
  int  gap = 0;
  bit  seen_on = 0;
  bit  prev_hs = 0, prev_ls = 0;
  always @(negedge clk) begin
    check("R5", hs, m_phase == 1, "hs_gate_en");
    check("R6", ls, m_phase == 2, "ls_gate_en");
    check("R3", lim, m_trip, "limit_active");
    check("R8", hs && ls, 1'b0, "overlap");
    if (rst) begin gap = 0; seen_on = 0; end
    else begin
      if ((hs && !prev_hs) || (ls && !prev_ls)) begin
        if (seen_on) begin
          checks++;
          if (gap != DEAD) begin
            errors++;
            $display("FAIL R7 dead gap actual=%0d expected=%0d", gap, DEAD);
          end
        end
        seen_on = 1;
      end
      gap = (hs || ls) ? 0 : gap + 1;
    end
    prev_hs = hs; prev_ls = ls;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic period(int hi, int lo);
    pwm = 1'b1; cyc(hi);
    pwm = 1'b0; cyc(lo);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    cyc(4);
    check("R1", hs, 0, "hs in reset");
    check("R1", ls, 0, "ls in reset");
    check("R1", lim, 0, "lim in reset");
    rst = 1'b0;
    cyc(10);
    check("R6", ls, 1, "ls with pwm low");

    // R5 plain periods of several duties
    period(20, 20);
    period(12, 30);
    period(40, 10);

    // R2 pulse only inside the blanking window
    pwm = 1'b1; cyc(1);
    oc = 1'b1; cyc(2);
    oc = 1'b0; cyc(10);
    check("R2", lim, 0, "blanked pulse");
    check("R5", hs, 1, "hs after blanked pulse");

    // R9 latency, R3 hold after flag clears, R6 low side while tripped
    cyc(5);
    oc = 1'b1; cyc(2);
    check("R9", lim, 0, "lim before sync delay");
    cyc(1);
    check("R9", lim, 1, "lim after sync delay");
    oc = 1'b0; cyc(8);
    check("R3", hs, 0, "hs held off");
    check("R3", lim, 1, "latch held");
    check("R6", ls, 1, "ls during trip");
    pwm = 1'b0; cyc(10);
    pwm = 1'b1; cyc(1);
    check("R4", lim, 0, "cleared at next rise");
    cyc(20);
    check("R5", hs, 1, "hs back on next period");
    pwm = 1'b0; cyc(10);

    // R10 flag while pwm low
    oc = 1'b1; cyc(12);
    check("R10", lim, 0, "flag with pwm low");
    check("R10", ls, 1, "ls unaffected");
    oc = 1'b0; cyc(4);

    // flag held over whole periods: trip re-armed every period
    oc = 1'b1;
    period(30, 20);
    period(30, 20);
    pwm = 1'b1; cyc(20);
    check("R3", lim, 1, "trip each period");
    pwm = 1'b0; oc = 1'b0; cyc(10);

    // R1 mid-run reset
    pwm = 1'b1; cyc(15);
    rst = 1'b1; cyc(1);
    check("R1", hs, 0, "hs after reset edge");
    check("R1", lim, 0, "lim after reset edge");
    rst = 1'b0; pwm = 1'b0; cyc(10);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule